// File: doc/BRIEF.md
# Interrupt and Trap Request Controller

This block collects four maskable interrupt request pins and one trap request pin that no mask can block. It brings them into the processor clock domain and keeps each new request pending until it is serviced. When a request is chosen, the block waits out a fixed minimum latency and any wait states of the core. It then hands control to the core. In that cycle it raises a branch request with the service address. In the same cycle it drives a 4-bit source code on the vector pins and pulses the acknowledge pin.

Request pins are sampled on the falling clock edge through a short synchronizer chain. Only a rising level on a pin creates a pending request, so a pin that stays high is serviced once. The core supplies an interrupt enable mask and a ready signal. The ready signal marks the instruction boundary at which a branch may be taken. A trap that arrives while an interrupt is waiting for the core takes over the service slot.

Top module: `irq_trap_ctrl`

## Requirements
- R1: While rst_ni is low, and after its release with no request, iack_o, br_req_o, vec_o and br_addr_o are all zero.
- R2: A request pin is captured on the falling clock edge. A pin raised between a rising and a falling edge and held for two cycles, with the block idle and core_rdy_i high, is acknowledged: iack_o is high after the sixth rising edge counted from the pin change.
- R3: Requests are edge sensitive. A pin held high for many cycles is serviced exactly once, and a later fresh rising level is serviced again.
- R4: During acknowledge, vec_o is 1, 2, 3 or 4 for interrupt pins 0 to 3 and 15 for the trap. At all other times it is 0. br_addr_o equals VEC_BASE + vec_o * VEC_STRIDE (defaults 0 and 4) while br_req_o is high, and 0 otherwise.
- R5: iack_o and br_req_o are high together for exactly one cycle per service.
- R6: When several requests are eligible, the trap wins, then interrupt 0, 1, 2 and 3. A service never follows the previous one by fewer than four cycles; with core_rdy_i high the next service comes exactly four cycles later.
- R7: A request on a masked pin (irq_en_i bit low) is not serviced but stays pending. It is serviced four cycles after its enable bit is set.
- R8: The trap is serviced with irq_en_i all zero.
- R9: A service is taken only on a rising edge where core_rdy_i is high. If core_rdy_i is low when the latency has elapsed, the service follows the first edge with core_rdy_i high.
- R10: If the selected interrupt is masked while it waits for the core, that service is dropped and the request stays pending.
- R11: A trap that arrives while an interrupt waits for core_rdy_i is serviced before that interrupt, and the interrupt is serviced afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 4 | Raw interrupt request pins, active high |
| trap_i | input | 1 | Raw trap request pin, active high |
| irq_en_i | input | 4 | Interrupt enable mask from the core |
| core_rdy_i | input | 1 | Core at an instruction boundary (low during wait states) |
| br_req_o | output | 1 | Branch request to the core |
| br_addr_o | output | 16 | Service address, valid with br_req_o |
| vec_o | output | 4 | Source code of the serviced request |
| iack_o | output | 1 | Acknowledge pulse |

## Verification
The assertions assume that irq_en_i and core_rdy_i are stable at each rising edge. They also assume that request pins do not change near a falling edge, so each synchronizer stage sees a clean level. The bench changes every input two time units after a rising edge, far from both edges. It keeps each pulse high for at least two cycles. This keeps the pin-to-acknowledge latency fixed, so the bench can check it to the exact cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_WAIT
  } seq_st_e;

  localparam logic [3:0] VEC_NONE = 4'h0;
  localparam logic [3:0] VEC_TRAP = 4'hF;

  // source index n_irq is the trap, lower indices are interrupt pins
  function automatic logic [3:0] src_code(input int idx, input int n_irq);
    if (idx == n_irq) return VEC_TRAP;
    return 4'(idx + 1);
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int N      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] rise_o
);

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [STAGES:0] chain;

    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '0;
      else         chain <= {chain[STAGES-1:0], pin_i[g]};
    end

    // high for one full cycle, straddling exactly one rising edge
    assign rise_o[g] = chain[STAGES-1] & ~chain[STAGES];
  end

endmodule

// File: rtl/irq_pend_arb.sv
module irq_pend_arb #(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N:0]       rise_i,
  input  logic [N:0]       clr_i,
  input  logic [N-1:0]     en_i,
  output logic             elig_o,
  output logic [IDX_W-1:0] win_o,
  output logic             trap_pend_o
);

  logic [N:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | rise_i;
  end

  always_comb begin
    win_o  = '0;
    elig_o = pend_q[N] | (|(pend_q[N-1:0] & en_i));
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_q[i] && en_i[i]) win_o = IDX_W'(i);
    end
    if (pend_q[N]) win_o = IDX_W'(N);
  end

  assign trap_pend_o = pend_q[N];

endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_pkg::*;
#(
  parameter int          N          = 4,
  parameter int          MIN_LAT    = 4,
  parameter int          ADDR_W     = 16,
  parameter int unsigned VEC_BASE   = 0,
  parameter int unsigned VEC_STRIDE = 4,
  parameter int          IDX_W      = $clog2(N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              elig_i,
  input  logic [IDX_W-1:0]  win_i,
  input  logic              trap_pend_i,
  input  logic [N-1:0]      en_i,
  input  logic              rdy_i,
  output logic [N:0]        clr_o,
  output logic              br_req_o,
  output logic [ADDR_W-1:0] br_addr_o,
  output logic [3:0]        vec_o,
  output logic              iack_o
);

  // two of the minimum latency cycles are spent in pending and selection
  localparam int LAT_WAIT = MIN_LAT - 2;
  localparam int LAT_W    = $clog2(LAT_WAIT + 1);

  seq_st_e          st_q;
  logic [IDX_W-1:0] sel_q;
  logic [LAT_W-1:0] lat_q;
  logic             sel_is_trap, sel_en, lat_done;
  logic             preempt, abort, fire;
  logic [3:0]       code;

  assign sel_is_trap = (sel_q == IDX_W'(N));
  assign lat_done    = (lat_q == LAT_W'(LAT_WAIT));

  always_comb begin
    sel_en = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel_q == IDX_W'(i)) sel_en = en_i[i];
    end
  end

  assign preempt = (st_q == ST_WAIT) && !sel_is_trap && trap_pend_i;
  assign abort   = (st_q == ST_WAIT) && !preempt && !sel_is_trap && !sel_en;
  assign fire    = (st_q == ST_WAIT) && !preempt && !abort && lat_done && rdy_i;
  assign code    = src_code(int'(sel_q), N);

  always_comb begin
    clr_o = '0;
    for (int i = 0; i <= N; i++) begin
      if (fire && sel_q == IDX_W'(i)) clr_o[i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      sel_q <= '0;
      lat_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (elig_i) begin
            st_q  <= ST_WAIT;
            sel_q <= win_i;
            lat_q <= '0;
          end
        end
        ST_WAIT: begin
          if (preempt) begin
            sel_q <= IDX_W'(N);
            lat_q <= '0;
          end else if (abort || fire) begin
            st_q <= ST_IDLE;
          end else if (!lat_done) begin
            lat_q <= lat_q + LAT_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iack_o    <= 1'b0;
      br_req_o  <= 1'b0;
      vec_o     <= VEC_NONE;
      br_addr_o <= '0;
    end else begin
      iack_o    <= fire;
      br_req_o  <= fire;
      vec_o     <= fire ? code : VEC_NONE;
      br_addr_o <= fire ? ADDR_W'(VEC_BASE) + ADDR_W'(code) * ADDR_W'(VEC_STRIDE) : '0;
    end
  end

endmodule

// File: rtl/irq_trap_ctrl.sv
module irq_trap_ctrl #(
  parameter int          N_IRQ       = 4,
  parameter int          SYNC_STAGES = 2,
  parameter int          MIN_LAT     = 4,
  parameter int          ADDR_W      = 16,
  parameter int unsigned VEC_BASE    = 0,
  parameter int unsigned VEC_STRIDE  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic              trap_i,
  input  logic [N_IRQ-1:0]  irq_en_i,
  input  logic              core_rdy_i,
  output logic              br_req_o,
  output logic [ADDR_W-1:0] br_addr_o,
  output logic [3:0]        vec_o,
  output logic              iack_o
);

  localparam int IDX_W = $clog2(N_IRQ + 1);

  logic [N_IRQ:0]   rise, clr;
  logic             elig, trap_pend;
  logic [IDX_W-1:0] win;

  irq_sync #(.N(N_IRQ + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  ({trap_i, irq_i}),
    .rise_o (rise)
  );

  irq_pend_arb #(.N(N_IRQ), .IDX_W(IDX_W)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_i      (rise),
    .clr_i       (clr),
    .en_i        (irq_en_i),
    .elig_o      (elig),
    .win_o       (win),
    .trap_pend_o (trap_pend)
  );

  irq_seq #(
    .N(N_IRQ), .MIN_LAT(MIN_LAT), .ADDR_W(ADDR_W),
    .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE), .IDX_W(IDX_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .elig_i      (elig),
    .win_i       (win),
    .trap_pend_i (trap_pend),
    .en_i        (irq_en_i),
    .rdy_i       (core_rdy_i),
    .clr_o       (clr),
    .br_req_o    (br_req_o),
    .br_addr_o   (br_addr_o),
    .vec_o       (vec_o),
    .iack_o      (iack_o)
  );

endmodule

// File: rtl/irq_trap_ctrl_chk.sv
module irq_trap_ctrl_chk #(
  parameter int          N_IRQ      = 4,
  parameter int          MIN_LAT    = 4,
  parameter int          ADDR_W     = 16,
  parameter int unsigned VEC_BASE   = 0,
  parameter int unsigned VEC_STRIDE = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_IRQ-1:0]  irq_en_i,
  input logic              core_rdy_i,
  input logic              br_req_o,
  input logic [ADDR_W-1:0] br_addr_o,
  input logic [3:0]        vec_o,
  input logic              iack_o
);

  logic [N_IRQ-1:0] en_q;
  logic             en_at_vec;
  logic [7:0]       gap_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      en_q <= irq_en_i;
      if (iack_o) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
      end else if (gap_q != 8'hFF) begin
        gap_q <= gap_q + 8'd1;
      end
    end
  end

  always_comb begin
    en_at_vec = 1'b0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (vec_o == 4'(i + 1)) en_at_vec = en_q[i];
    end
  end

  AST_IACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_o |=> !iack_o); // R5
  AST_BR_WITH_IACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_req_o |-> iack_o); // R5
  AST_VEC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iack_o |-> (vec_o == 4'h0 && br_addr_o == '0)); // R4
  AST_VEC_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_o |-> (vec_o == 4'hF || (vec_o >= 4'd1 && vec_o <= 4'(N_IRQ)))); // R4
  AST_ADDR_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_o |-> br_addr_o == ADDR_W'(VEC_BASE) + ADDR_W'(vec_o) * ADDR_W'(VEC_STRIDE)); // R4
  AST_RDY_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_o |-> $past(core_rdy_i)); // R9
  AST_MASK_RESPECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_o && vec_o != 4'hF) |-> en_at_vec); // R7
  AST_MIN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_o && seen_q) |-> gap_q >= 8'(MIN_LAT - 1)); // R6

endmodule

bind irq_trap_ctrl irq_trap_ctrl_chk #(
  .N_IRQ(N_IRQ), .MIN_LAT(MIN_LAT), .ADDR_W(ADDR_W),
  .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (.*);

// File: tb/irq_trap_ctrl_test.sv
module irq_trap_ctrl_test;

  localparam int CLK_T = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  irq = '0;
  logic        trap = 1'b0;
  logic [3:0]  en = 4'hF;
  logic        rdy = 1'b1;
  logic        br_req, iack;
  logic [15:0] br_addr;
  logic [3:0]  vec;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_T / 2) clk = ~clk;

  irq_trap_ctrl uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .irq_i      (irq),
    .trap_i     (trap),
    .irq_en_i   (en),
    .core_rdy_i (rdy),
    .br_req_o   (br_req),
    .br_addr_o  (br_addr),
    .vec_o      (vec),
    .iack_o     (iack)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // waits up to max_cyc edges; cyc = 0 when no acknowledge was seen
  task automatic wait_iack(input int max_cyc, output int cyc, output int code);
    cyc  = 0;
    code = 0;
    for (int k = 1; k <= max_cyc; k++) begin
      step();
      if (iack) begin
        cyc  = k;
        code = int'(vec);
        return;
      end
    end
  endtask

  task automatic count_iack(input int cycles, output int cnt);
    cnt = 0;
    for (int k = 0; k < cycles; k++) begin
      step();
      if (iack) cnt++;
    end
  endtask

  task automatic pulse_irq(input int idx);
    irq[idx] = 1'b1;
    fork
      begin
        repeat (2) @(posedge clk);
        #2 irq[idx] = 1'b0;
      end
    join_none
  endtask

  task automatic pulse_trap();
    trap = 1'b1;
    fork
      begin
        repeat (2) @(posedge clk);
        #2 trap = 1'b0;
      end
    join_none
  endtask

  task automatic t_reset();
    check(!iack && !br_req && vec == 0 && br_addr == 0, "R1 in reset", int'(vec), 0);
    #(CLK_T * 2);
    rst_n = 1'b1;
    repeat (4) step();
    check(!iack && !br_req && vec == 0 && br_addr == 0, "R1 after reset", int'(iack), 0);
  endtask

  task automatic t_single(input int idx);
    int cyc, code;
    step();
    pulse_irq(idx);
    wait_iack(12, cyc, code);
    check(cyc == 6, "R2 latency", cyc, 6);
    check(code == idx + 1, "R4 vec code", code, idx + 1);
    check(br_req == 1'b1, "R5 br_req with iack", int'(br_req), 1);
    check(int'(br_addr) == (idx + 1) * 4, "R4 br_addr", int'(br_addr), (idx + 1) * 4);
    step();
    check(!iack && !br_req && vec == 0, "R5 single cycle", int'(iack), 0);
    repeat (3) step();
  endtask

  task automatic t_priority();
    int cyc, code;
    step();
    pulse_irq(3);
    pulse_irq(1);
    wait_iack(12, cyc, code);
    check(code == 2, "R6 irq1 before irq3", code, 2);
    wait_iack(12, cyc, code);
    check(code == 4, "R6 irq3 second", code, 4);
    check(cyc == 4, "R6 gap", cyc, 4);
    step();
    pulse_irq(0);
    pulse_trap();
    wait_iack(12, cyc, code);
    check(code == 15, "R6 trap first", code, 15);
    wait_iack(12, cyc, code);
    check(code == 1, "R6 irq0 after trap", code, 1);
    repeat (3) step();
  endtask

  task automatic t_mask();
    int cyc, code, cnt;
    en = 4'b1011;
    step();
    pulse_irq(2);
    count_iack(20, cnt);
    check(cnt == 0, "R7 masked not served", cnt, 0);
    en = 4'hF;
    wait_iack(12, cyc, code);
    check(cyc == 4, "R7 served after enable", cyc, 4);
    check(code == 3, "R7 code", code, 3);
    repeat (3) step();
  endtask

  task automatic t_trap_unmasked();
    int cyc, code;
    en = 4'h0;
    step();
    pulse_trap();
    wait_iack(12, cyc, code);
    check(cyc == 6 && code == 15, "R8 trap with mask zero", code, 15);
    check(int'(br_addr) == 60, "R4 trap addr", int'(br_addr), 60);
    en = 4'hF;
    repeat (3) step();
  endtask

  task automatic t_wait_states();
    int cyc, code, cnt;
    rdy = 1'b0;
    step();
    pulse_irq(0);
    count_iack(10, cnt);
    check(cnt == 0, "R9 held by wait state", cnt, 0);
    rdy = 1'b1;
    wait_iack(6, cyc, code);
    check(cyc == 1 && code == 1, "R9 served on ready", cyc, 1);
    repeat (3) step();
  endtask

  task automatic t_abort();
    int cyc, code, cnt;
    rdy = 1'b0;
    step();
    pulse_irq(1);
    repeat (8) step();
    en = 4'b1101;
    repeat (2) step();
    rdy = 1'b1;
    count_iack(10, cnt);
    check(cnt == 0, "R10 dropped when masked", cnt, 0);
    en = 4'hF;
    wait_iack(12, cyc, code);
    check(cyc == 4 && code == 2, "R10 still pending", code, 2);
    repeat (3) step();
  endtask

  task automatic t_trap_preempt();
    int cyc, code, cnt;
    rdy = 1'b0;
    step();
    pulse_irq(0);
    repeat (4) step();
    pulse_trap();
    count_iack(8, cnt);
    check(cnt == 0, "R11 none while stalled", cnt, 0);
    rdy = 1'b1;
    wait_iack(6, cyc, code);
    check(code == 15, "R11 trap takes slot", code, 15);
    wait_iack(12, cyc, code);
    check(code == 1 && cyc == 4, "R11 irq0 afterwards", code, 1);
    repeat (3) step();
  endtask

  task automatic t_edge();
    int cyc, code, cnt;
    step();
    irq[3] = 1'b1;
    count_iack(30, cnt);
    check(cnt == 1, "R3 held pin served once", cnt, 1);
    irq[3] = 1'b0;
    repeat (4) step();
    pulse_irq(3);
    wait_iack(12, cyc, code);
    check(cyc == 6 && code == 4, "R3 fresh edge served", code, 4);
    repeat (3) step();
  endtask

  initial begin
    #(CLK_T * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    for (int i = 0; i < 4; i++) t_single(i);
    t_priority();
    t_mask();
    t_trap_unmasked();
    t_wait_states();
    t_abort();
    t_trap_preempt();
    t_edge();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule